// File: doc/BRIEF.md
# Page Write Buffer with Timed Programming

This block sits behind the command decoder of a serial non-volatile memory. When a write command opens, it receives the start address. It then collects each complete data byte into a page-sized latch and keeps one "loaded" flag per byte. The latch is one page wide. Its column pointer starts at the low address bits and moves up one byte at a time. Past the last column it wraps back to column zero of the same page, so a long burst overwrites bytes that were loaded earlier.

When chip select rises, the decoder reports three things: the rise itself, whether it fell exactly after the last bit of a byte, and a single permit bit. The permit bit already covers the enable latch and block protection. If all three are good and at least one byte was loaded, a self-timed program cycle starts; otherwise the command is dropped. During the cycle the busy flag is high. The loaded bytes go to the array port in ascending column order, one per clock. In the final busy cycle a one-clock pulse tells the decoder to clear its write-enable latch. Nothing arriving during the cycle disturbs it.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy`, `mem_we` and `wel_clr` are 0.
- R2: `cmd_start` splits `cmd_addr` into a page number (bits ADDR_W-1..6) and a column (bits 5..0) and discards any earlier loaded bytes. Each `byte_vld` stores `byte_data` at the current column and advances the column by one. A second `cmd_start` before chip select rises restarts the collection.
- R3: After column 63 the column wraps to 0 of the same page. A byte loaded at an already loaded column replaces the earlier byte.
- R4: A program cycle starts only when `cs_rise` arrives while a command is open, with `cs_aligned`=1, `permit`=1 and at least one byte loaded. In every other case the command is dropped: no array write, no `busy`, no `wel_clr`.
- R5: After an accepted `cs_rise`, `busy` is 1 from the next clock for exactly PROG_CYCLES clocks.
- R6: During the cycle, only loaded columns are written. They are written in ascending column order, one per clock, within the first 64 busy clocks, at address {page, column} with the latest loaded byte. Unloaded columns of the page get no write.
- R7: `wel_clr` is a one-clock pulse in the last busy clock of an accepted cycle. It never appears for a dropped command.
- R8: During `busy`, `cmd_start`, `byte_vld`, `cs_rise`, `cs_aligned` and `permit` have no effect. The cycle runs its full length, and when it ends no command is open.
- R9: `byte_vld` and `cs_rise` with no open command are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Opens a write command, captures `cmd_addr` |
| cmd_addr | input | ADDR_W | Start byte address of the write |
| byte_vld | input | 1 | One complete data byte is present |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip-select rising edge event |
| cs_aligned | input | 1 | The rise came right after the last bit of a byte |
| permit | input | 1 | Enable latch set and target page not protected |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Clear the write-enable latch (one clock) |

## Verification
The assertions assume that every input is a one-clock event pulse, that `cmd_start` and `cs_rise` never share a clock, and that PROG_CYCLES is at least the page size, so the whole column scan fits inside the busy window. The stimulus drives every input on the falling clock edge and holds each event high for exactly one clock. It still sends starts, bytes, chip-select rises and permit changes while the cycle is running, so the checks on cycle length and scan order are exercised under noise.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int PAGE_BYTES = 64,
  parameter int DATA_W     = 8,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic [COL_W-1:0]  init_col,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  // Column advance with wrap inside the page (works for any page size).
  function automatic logic [COL_W-1:0] next_col(input logic [COL_W-1:0] c);
    return (c == LAST_COL) ? '0 : c + COL_W'(1);
  endfunction

  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        col_q <= '0;
    else if (init_en)  col_q <= init_col;
    else if (load_en)  col_q <= next_col(col_q);
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
    logic hit;
    assign hit = load_en && (col_q == COL_W'(g));

    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= load_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld_q[g] <= 1'b0;
      else if (init_en) vld_q[g] <= 1'b0;
      else if (hit)     vld_q[g] <= 1'b1;
    end
  end

  assign rd_data = data_q[rd_col];
  assign rd_vld  = vld_q[rd_col];
  assign any_vld = |vld_q;
endmodule

// File: rtl/pwb_prog_timer.sv
module pwb_prog_timer #(
  parameter int PROG_CYCLES = 100,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (run)    cnt <= cnt + CNT_W'(1);
  end

  assign last = run && (cnt == LAST_CNT);
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic byte_vld,
  input  logic cs_rise,
  input  logic cs_aligned,
  input  logic permit,
  input  logic any_vld,
  input  logic prog_last,
  output logic init_en,
  output logic load_en,
  output logic commit_go,
  output logic abort_go,
  output logic busy
);
  pwb_state_e state_q, state_d;

  logic open_cmd;
  assign open_cmd  = (state_q == ST_LOAD);
  assign busy      = (state_q == ST_PROG);
  // Chip-select rise closes an open command; it wins over start and data.
  assign commit_go = open_cmd && cs_rise && cs_aligned && permit && any_vld;
  assign abort_go  = open_cmd && cs_rise && !commit_go;
  assign init_en   = cmd_start && !busy && !(open_cmd && cs_rise);
  assign load_en   = byte_vld && open_cmd && !cs_rise && !cmd_start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (init_en) state_d = ST_LOAD;
      ST_LOAD: begin
        if (commit_go)     state_d = ST_PROG;
        else if (abort_go) state_d = ST_IDLE;
      end
      ST_PROG: if (prog_last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 100,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - COL_W,
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              permit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              wel_clr
);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  // Named internal events (observed by the bound checker).
  logic init_en, load_en, commit_go, abort_go, any_vld;
  logic prog_last, scan_act, rd_vld;
  logic [CNT_W-1:0]  prog_cnt;
  logic [COL_W-1:0]  scan_col;
  logic [PAGE_W-1:0] page_q;

  pwb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .byte_vld  (byte_vld),
    .cs_rise   (cs_rise),
    .cs_aligned(cs_aligned),
    .permit    (permit),
    .any_vld   (any_vld),
    .prog_last (prog_last),
    .init_en   (init_en),
    .load_en   (load_en),
    .commit_go (commit_go),
    .abort_go  (abort_go),
    .busy      (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (init_en) page_q <= page_of(cmd_addr);
  end

  pwb_page_latch #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_en  (init_en),
    .init_col (col_of(cmd_addr)),
    .load_en  (load_en),
    .load_data(byte_data),
    .rd_col   (scan_col),
    .rd_data  (mem_wdata),
    .rd_vld   (rd_vld),
    .any_vld  (any_vld)
  );

  pwb_prog_timer #(
    .PROG_CYCLES(PROG_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(commit_go),
    .run  (busy),
    .cnt  (prog_cnt),
    .last (prog_last)
  );

  // The first PAGE_BYTES busy clocks scan the latch column by column.
  assign scan_col = prog_cnt[COL_W-1:0];
  assign scan_act = busy && (prog_cnt < SCAN_END);
  assign mem_we   = scan_act && rd_vld;
  assign mem_addr = {page_q, scan_col};
  assign wel_clr  = prog_last;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 100,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int BC_W       = $clog2(PROG_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              wel_clr,
  input logic              commit_go
);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(PROG_CYCLES - 1);
  localparam logic [BC_W-1:0] BC_SCAN = BC_W'(PAGE_BYTES);

  // Counts the busy clocks, so the window length can be checked without deep $past.
  logic [BC_W-1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + BC_W'(1);
    else           bcnt <= '0;
  end

  assert_busy_from_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit_go));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt <= BC_LAST);

  assert_we_in_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && bcnt < BC_SCAN));

  assert_page_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:COL_W]));

  assert_wel_clr_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> (busy && bcnt == BC_LAST));

  assert_wel_clr_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !busy);

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel_clr) |=> busy);
endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .wel_clr  (wel_clr),
  .commit_go(commit_go)
);

// File: tb/page_write_buffer_tb.sv
module page_write_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 14;
  localparam int PAGE       = 64;
  localparam int PROG       = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, byte_vld = 0, cs_rise = 0, cs_aligned = 0, permit = 0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [7:0] byte_data = '0;
  logic mem_we, busy, wel_clr;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_write_buffer #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .permit(permit), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .wel_clr(wel_clr)
  );

  typedef struct packed { logic [ADDR_W-1:0] addr; logic [7:0] data; } wr_item_t;
  wr_item_t exp_q[$];

  int checks = 0, failures = 0;
  logic finished = 1'b0;
  logic [7:0] m_data [PAGE];
  logic       m_vld  [PAGE];
  logic [ADDR_W-7:0] m_page;

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: every array write must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && mem_we && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4/R6", "unexpected write addr", int'(mem_addr), -1);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(mem_addr == it.addr && mem_wdata == it.data, "R6", "write addr",
              int'(mem_addr), int'(it.addr));
        if (mem_wdata != it.data)
          $display("  data actual=%0d expected=%0d", mem_wdata, it.data);
      end
    end
  end

  // Driver: opens a command and streams n bytes, keeping its own page model.
  task automatic load(input logic [ADDR_W-1:0] a, input int n, input int base);
    int col;
    m_page = a[ADDR_W-1:6];
    col = int'(a[5:0]);
    for (int c = 0; c < PAGE; c++) m_vld[c] = 1'b0;
    @(negedge clk); cmd_start = 1; cmd_addr = a;
    @(negedge clk); cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1; byte_data = 8'(base + i);
      m_data[col] = 8'(base + i); m_vld[col] = 1'b1;
      col = (col + 1) % PAGE;
      @(negedge clk);
    end
    byte_vld = 0;
  endtask

  task automatic push_expected();
    for (int c = 0; c < PAGE; c++)
      if (m_vld[c]) exp_q.push_back({m_page, 6'(c), m_data[c]});
  endtask

  // Accepted chip-select rise: measures the busy window and the clear pulse.
  task automatic commit(input string req, input logic noisy);
    int n = 0, wc = 0, wpos = -1;
    push_expected();
    cs_aligned = 1; permit = 1; cs_rise = 1;
    @(negedge clk); cs_rise = 0;
    while (busy && n < PROG + 5) begin
      n++;
      if (wel_clr) begin wc++; wpos = n; end
      if (noisy && n >= 5 && n < 12) begin
        cmd_start = n[0]; cmd_addr = 14'h0155; byte_vld = 1; byte_data = 8'hEE;
        cs_rise = ~n[0]; cs_aligned = n[1]; permit = n[0];
      end else begin
        cmd_start = 0; byte_vld = 0; cs_rise = 0; permit = 1;
      end
      @(negedge clk);
    end
    check(n == PROG, req, "busy length R5", n, PROG);
    check(wc == 1 && wpos == PROG, "R7", "wel_clr position", wpos, PROG);
    check(exp_q.size() == 0, req, "pending writes", exp_q.size(), 0);
  endtask

  task automatic expect_idle(input int cycles, input string req);
    logic ok = 1'b1;
    repeat (cycles) begin
      @(negedge clk);
      if (busy || wel_clr || mem_we) ok = 1'b0;
    end
    check(ok, req, "no cycle expected, busy", int'(busy), 0);
  endtask

  task automatic drop(input logic al, input logic pm, input string req);
    cs_aligned = al; permit = pm; cs_rise = 1;
    @(negedge clk); cs_rise = 0; cs_aligned = 0; permit = 0;
    expect_idle(PROG + 4, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !mem_we && !wel_clr, "R1", "reset outputs busy", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !wel_clr, "R1", "after release busy", int'(busy), 0);

    load(14'h1245, 1, 8'h5A);            // R2: single byte
    commit("R2", 1'b0);

    load(14'h26BE, 4, 8'h10);            // R3: cols 62,63,0,1
    commit("R3", 1'b0);

    load(14'h00BE, 66, 8'h80);           // R3: 66 bytes, cols 62/63 overwritten
    commit("R3", 1'b0);

    load(14'h0300, 3, 8'h20);            // R4: rise off byte boundary
    drop(1'b0, 1'b1, "R4");
    load(14'h0300, 3, 8'h20);            // R4: permit low
    drop(1'b1, 1'b0, "R4");
    load(14'h0300, 0, 8'h00);            // R4: no bytes loaded
    drop(1'b1, 1'b1, "R4");

    load(14'h3FC0, 2, 8'hA0);            // R2: restart discards first bytes
    load(14'h3FE0, 2, 8'hB0);
    commit("R2", 1'b0);

    load(14'h0480, 5, 8'h40);            // R8: noise while busy
    commit("R8", 1'b1);
    drop(1'b1, 1'b1, "R8");              // no command open after cycle

    @(negedge clk); byte_vld = 1; byte_data = 8'h77;   // R9: idle bytes
    @(negedge clk); byte_vld = 0;
    drop(1'b1, 1'b1, "R9");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6", "leftover expected writes", exp_q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule